// File: doc/BRIEF.md
# Memory-Region Scoreboard for a Block-Copy Accelerator

This block lets a processor keep running while a memory-to-memory accelerator works on its behalf, without giving up the look of in-order execution. Each accelerator operation names a function code, one region it reads and one region it writes. Each region is given as a base address and a log2 size, so it covers a power-of-two, size-aligned block. When the block accepts an operation, it takes a scoreboard slot and holds both regions there until the accelerator reports completion with the slot's tag.

While a slot is held, the block watches every processor memory access. A store that touches either region of the slot, or a load that touches its written region, gets a stall. A load that only touches a region being read goes ahead. A later accelerator operation is refused in the same way when it would break program order. That is the case when its written region meets any held region, or its read region meets a held written region. Two operations that only read the same data may overlap. Nothing carries over from one operation to the next.

Each slot is a two-state machine, SLOT_FREE and SLOT_HELD. It moves from SLOT_FREE to SLOT_HELD by the ALLOCATE transition, taken when an issue is accepted and this slot is the lowest free one. It moves back by the RETIRE transition, taken when a completion names its tag. An occupancy machine with the states OCC_EMPTY, OCC_PART and OCC_FULL counts the held slots and drives the busy and full outputs. Its transitions are FILL (one more slot held), DRAIN (one fewer) and HOLD (no change).

Top module: `memsb_top`

## Requirements
- R1: After reset all slots are free: `busy`, `full`, `acc_stall`, `iss_accept`, `iss_conflict` and `iss_err` are 0, and `iss_tag` is 0.
- R2: An issue with `iss_valid`=1, a valid function code, a free slot and no conflict is accepted in the same cycle (`iss_accept`=1). `iss_tag` equals the lowest-numbered free slot. From the next cycle that slot is held and `busy`=1.
- R3: Function codes 14 and 15 are illegal. With `iss_valid`=1 they raise `iss_err`=1, `iss_accept`=0, and no slot is taken.
- R4: A processor store (`acc_valid`=1, `acc_store`=1) to an address inside the read region or the written region of any held slot sets `acc_stall`=1 in the same cycle.
- R5: A processor load (`acc_store`=0) inside the written region of a held slot stalls. A load that falls only inside held read regions does not stall.
- R6: A region with base B and log2 size L covers exactly the addresses whose bits at position L and above equal those bits of B. Bits of B below L are ignored, so two regions meet when they agree above the larger of their two sizes.
- R7: An issue whose written region meets a held read region or a held written region, or whose read region meets a held written region, is refused with `iss_conflict`=1. An issue whose read region only meets held read regions is accepted.
- R8: When all 4 slots are held, `full`=1, and any issue is refused with `iss_accept`=0 and `iss_tag`=0.
- R9: A completion (`cmp_valid`=1, `cmp_tag`=t) on a held slot frees it at the clock edge. A stall or conflict caused by that slot is still present in the completion cycle and gone in the following cycle.
- R10: A completion naming a free slot has no effect. A completion of one slot does not release the locks of any other held slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Accelerator issue request |
| iss_func | input | 4 | Function code of the request |
| iss_src_base | input | 32 | Base address of the region read |
| iss_src_lg | input | 5 | log2 size of the region read |
| iss_dst_base | input | 32 | Base address of the region written |
| iss_dst_lg | input | 5 | log2 size of the region written |
| iss_accept | output | 1 | Request accepted this cycle |
| iss_tag | output | 2 | Lowest free slot (the tag given on accept), 0 when full |
| iss_conflict | output | 1 | Request overlaps held regions in an order-breaking way |
| iss_err | output | 1 | Request carries an illegal function code |
| cmp_valid | input | 1 | Accelerator completion |
| cmp_tag | input | 2 | Slot that completed |
| acc_valid | input | 1 | Processor memory access to check |
| acc_store | input | 1 | 1 for store, 0 for load |
| acc_addr | input | 32 | Processor access address |
| acc_stall | output | 1 | Processor access must wait |
| busy | output | 1 | At least one slot held |
| full | output | 1 | All slots held |

## Verification
The processor side is driven with loads and stores aimed at the read region, at the written region, and at the first address past a region. These tell the read/write asymmetry apart from a plain address match, and they expose a mask that is off by one bit. The issue side is driven with read-after-write, write-after-read and write-after-write overlaps, with a read-read overlap that must pass, and with a region large enough to cover all held slots. This separates each direction of the overlap test. Completions are sent to held slots, to an already-free slot, and in the same cycle as a new issue, so that an early or late release and a release of the wrong slot each show up as a wrong stall or tag.

// File: rtl/memsb_pkg.sv
package memsb_pkg;

    // lifecycle of one scoreboard slot
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    // occupancy of the whole table
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/memsb_slot.sv
module memsb_slot
    import memsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              retire,
    input  logic [ADDR_W-1:0] new_rd_base,
    input  logic [LG_W-1:0]   new_rd_lg,
    input  logic [ADDR_W-1:0] new_wr_base,
    input  logic [LG_W-1:0]   new_wr_lg,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              held,
    output logic              acc_hit,
    output logic              iss_hit
);

    slot_state_e       state_q, state_d;
    logic [ADDR_W-1:0] rd_base_q, wr_base_q;
    logic [LG_W-1:0]   rd_lg_q, wr_lg_q;

    // two aligned power-of-two regions meet when they agree above the larger size
    function automatic logic regions_meet(
        input logic [ADDR_W-1:0] a_base,
        input logic [LG_W-1:0]   a_lg,
        input logic [ADDR_W-1:0] b_base,
        input logic [LG_W-1:0]   b_lg
    );
        logic [LG_W-1:0]   big;
        logic [ADDR_W-1:0] keep;
        big  = (a_lg > b_lg) ? a_lg : b_lg;
        keep = ~((ADDR_W'(1) << big) - ADDR_W'(1));
        return ((a_base ^ b_base) & keep) == '0;
    endfunction

    // next state: ALLOCATE and RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (grant)  state_d = SLOT_HELD;
            SLOT_HELD: if (retire) state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // region capture on allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_base_q <= '0;
            wr_base_q <= '0;
            rd_lg_q   <= '0;
            wr_lg_q   <= '0;
        end else if (state_q == SLOT_FREE && grant) begin
            rd_base_q <= new_rd_base;
            wr_base_q <= new_wr_base;
            rd_lg_q   <= new_rd_lg;
            wr_lg_q   <= new_wr_lg;
        end
    end

    // outputs
    always_comb begin
        held    = 1'b0;
        acc_hit = 1'b0;
        iss_hit = 1'b0;
        unique case (state_q)
            SLOT_FREE: ;
            SLOT_HELD: begin
                held    = 1'b1;
                acc_hit = regions_meet(acc_addr, '0, wr_base_q, wr_lg_q)
                        | (acc_store & regions_meet(acc_addr, '0, rd_base_q, rd_lg_q));
                iss_hit = regions_meet(new_wr_base, new_wr_lg, rd_base_q, rd_lg_q)
                        | regions_meet(new_wr_base, new_wr_lg, wr_base_q, wr_lg_q)
                        | regions_meet(new_rd_base, new_rd_lg, wr_base_q, wr_lg_q);
            end
        endcase
    end

endmodule

// File: rtl/memsb_alloc.sv
module memsb_alloc #(
    parameter int SLOTS = 4,
    parameter int TAG_W = 2
) (
    input  logic [SLOTS-1:0] held,
    output logic             any_free,
    output logic [TAG_W-1:0] free_idx
);

    // lowest free slot wins; scan downward so the last write is the lowest
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!held[i]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/memsb_occ.sv
module memsb_occ
    import memsb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fill,
    input  logic drain,
    output logic busy,
    output logic full
);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // FILL, DRAIN or HOLD
    always_comb begin
        cnt_d = cnt_q;
        if (fill && !drain)      cnt_d = cnt_q + CNT_W'(1);
        else if (drain && !fill) cnt_d = cnt_q - CNT_W'(1);
        if (cnt_d == '0)                     state_d = OCC_EMPTY;
        else if (cnt_d == CNT_W'(SLOTS))     state_d = OCC_FULL;
        else                                 state_d = OCC_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy = 1'b0;
        full = 1'b0;
        unique case (state_q)
            OCC_EMPTY: ;
            OCC_PART:  busy = 1'b1;
            OCC_FULL:  begin busy = 1'b1; full = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/memsb_top.sv
module memsb_top #(
    parameter int ADDR_W     = 32,
    parameter int LG_W       = 5,
    parameter int FUNC_W     = 4,
    parameter int FUNC_COUNT = 14,
    parameter int SLOTS      = 4,
    localparam int TAG_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [FUNC_W-1:0] iss_func,
    input  logic [ADDR_W-1:0] iss_src_base,
    input  logic [LG_W-1:0]   iss_src_lg,
    input  logic [ADDR_W-1:0] iss_dst_base,
    input  logic [LG_W-1:0]   iss_dst_lg,
    output logic              iss_accept,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              iss_conflict,
    output logic              iss_err,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_stall,
    output logic              busy,
    output logic              full
);

    logic [SLOTS-1:0] held, acc_hit, iss_hit, grant, retire;
    logic             any_free;
    logic [TAG_W-1:0] free_idx;

    memsb_alloc #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_alloc (
        .held     (held),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign grant[g]  = iss_accept && (free_idx == TAG_W'(g));
        assign retire[g] = cmp_valid && (cmp_tag == TAG_W'(g));
        memsb_slot #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant       (grant[g]),
            .retire      (retire[g]),
            .new_rd_base (iss_src_base),
            .new_rd_lg   (iss_src_lg),
            .new_wr_base (iss_dst_base),
            .new_wr_lg   (iss_dst_lg),
            .acc_store   (acc_store),
            .acc_addr    (acc_addr),
            .held        (held[g]),
            .acc_hit     (acc_hit[g]),
            .iss_hit     (iss_hit[g])
        );
    end

    assign iss_err      = iss_valid && (iss_func >= FUNC_W'(FUNC_COUNT));
    assign iss_conflict = iss_valid && (|iss_hit);
    assign iss_accept   = iss_valid && !iss_err && !iss_conflict && any_free;
    assign iss_tag      = free_idx;
    assign acc_stall    = acc_valid && (|acc_hit);

    memsb_occ #(.SLOTS(SLOTS)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .fill  (iss_accept),
        .drain (|(retire & held)),
        .busy  (busy),
        .full  (full)
    );

endmodule

// File: rtl/memsb_checker.sv
module memsb_checker (
    input logic clk,
    input logic rst_n,
    input logic iss_valid,
    input logic iss_accept,
    input logic iss_conflict,
    input logic iss_err,
    input logic acc_stall,
    input logic busy,
    input logic full
);

    AST_FULL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !iss_accept); // R8
    AST_BAD_FUNC_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_err |-> !iss_accept); // R3
    AST_CONFLICT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_conflict |-> !iss_accept); // R7
    AST_ACCEPT_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |=> busy); // R2
    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> iss_valid); // R2
    AST_IDLE_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !acc_stall); // R4

endmodule

bind memsb_top memsb_checker u_chk (.*);

// File: tb/memsb_top_bench.sv
module memsb_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_func = '0;
    logic [31:0] iss_src_base = '0, iss_dst_base = '0;
    logic [4:0]  iss_src_lg = '0, iss_dst_lg = '0;
    logic        iss_accept, iss_conflict, iss_err;
    logic [1:0]  iss_tag;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_tag = '0;
    logic        acc_valid = 1'b0, acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_stall, busy, full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    memsb_top u_memsb_top (.*);

    typedef struct {
        string      req;
        logic [8:0] exp;
    } item_t;
    item_t q[$];

    // bench model of held slots
    bit          m_held[4];
    logic [31:0] m_rb[4], m_wb[4];
    logic [4:0]  m_rl[4], m_wl[4];

    function automatic bit meet(logic [31:0] a, logic [4:0] la, logic [31:0] b, logic [4:0] lb);
        int k;
        k = (la > lb) ? la : lb;
        return (a >> k) == (b >> k);
    endfunction

    task automatic step(string req,
                        bit iv, logic [3:0] fn, logic [31:0] sb, logic [4:0] sl,
                        logic [31:0] db, logic [4:0] dl,
                        bit cv, logic [1:0] ct,
                        bit av, bit st, logic [31:0] ad);
        bit err, conf, anyf, acc, stall, fl, bz;
        logic [1:0] idx;
        item_t it;
        @(negedge clk);
        #1;
        iss_valid = iss_valid; // keep ordering explicit
        iss_valid = iv; iss_func = fn; iss_src_base = sb; iss_src_lg = sl;
        iss_dst_base = db; iss_dst_lg = dl;
        cmp_valid = cv; cmp_tag = ct;
        acc_valid = av; acc_store = st; acc_addr = ad;
        err = iv && (fn >= 4'd14);
        conf = 0; stall = 0; anyf = 0; idx = 0; fl = 1; bz = 0;
        for (int j = 3; j >= 0; j--) begin
            if (!m_held[j]) begin anyf = 1; idx = 2'(j); end
        end
        for (int j = 0; j < 4; j++) begin
            if (m_held[j]) begin
                bz = 1;
                if (meet(db, dl, m_rb[j], m_rl[j]) || meet(db, dl, m_wb[j], m_wl[j]) ||
                    meet(sb, sl, m_wb[j], m_wl[j])) conf = iv;
                if (meet(ad, 0, m_wb[j], m_wl[j]) || (st && meet(ad, 0, m_rb[j], m_rl[j])))
                    stall = av;
            end else fl = 0;
        end
        acc = iv && !err && !conf && anyf;
        it.req = req;
        it.exp = {acc, idx, conf, err, stall, fl, bz};
        q.push_back(it);
        if (cv && m_held[ct]) m_held[ct] = 0;
        if (acc) begin
            m_held[idx] = 1; m_rb[idx] = sb; m_rl[idx] = sl; m_wb[idx] = db; m_wl[idx] = dl;
        end
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic probe(string req, bit st, logic [31:0] ad);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, st, ad);
    endtask

    task automatic issue(string req, logic [3:0] fn, logic [31:0] sb, logic [4:0] sl,
                         logic [31:0] db, logic [4:0] dl);
        step(req, 1, fn, sb, sl, db, dl, 0, 0, 0, 0, 0);
    endtask

    // monitor: compares the produced outputs with the queued expectation
    always @(negedge clk) begin
        item_t it;
        logic [8:0] act;
        #2;
        if (q.size() > 0) begin
            it = q.pop_front();
            act = {iss_accept, iss_tag, iss_conflict, iss_err, acc_stall, full, busy};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual {acc,tag,conf,err,stall,full,busy}=%b expected=%b",
                         it.req, act, it.exp);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 4; j++) m_held[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // R2 first accept takes slot 0
        issue("R2 first issue", 4'd3, 32'h1000, 5'd8, 32'h2000, 5'd8);
        idle("R2 busy after accept");
        probe("R4 store into written region", 1, 32'h2010);
        probe("R4 store into read region", 1, 32'h1080);
        probe("R5 load from written region", 0, 32'h20FF);
        probe("R5 load from read region passes", 0, 32'h1004);
        probe("R6 first address past region", 1, 32'h2100);
        probe("R6 address below region", 1, 32'h0FFF);
        issue("R3 function 14 illegal", 4'd14, 32'h9000, 5'd2, 32'hA000, 5'd2);
        issue("R3 function 15 illegal", 4'd15, 32'h9000, 5'd2, 32'hA000, 5'd2);
        issue("R7 read after held write", 4'd1, 32'h2040, 5'd4, 32'h3000, 5'd4);
        issue("R7 shared read accepted", 4'd2, 32'h1000, 5'd4, 32'h4000, 5'd6);
        issue("R7 write over held read", 4'd2, 32'h5000, 5'd2, 32'h1013, 5'd2);
        issue("R6 large region covers held", 4'd2, 32'h7000, 5'd2, 32'h0, 5'd16);
        issue("R2 third slot", 4'd0, 32'h5000, 5'd4, 32'h6000, 5'd4);
        issue("R2 fourth slot", 4'd13, 32'h7000, 5'd4, 32'h8000, 5'd4);
        issue("R8 full refuses", 4'd1, 32'hB000, 5'd4, 32'hC000, 5'd4);
        // R9 completion of slot 1 while probing its written region
        step("R9 stall held in completion cycle", 0, 0, 0, 0, 0, 0, 1, 2'd1, 1, 1, 32'h4004);
        probe("R9 stall cleared after completion", 1, 32'h4004);
        // R10 completion of free slot 1, slot 0 lock must remain
        step("R10 stale completion ignored", 0, 0, 0, 0, 0, 0, 1, 2'd1, 1, 0, 32'h2000);
        probe("R10 slot 0 still locks", 1, 32'h2000);
        // issue reusing slot 1 in the same cycle slot 2 completes
        step("R9 issue with other completion", 1, 4'd5, 32'hD000, 5'd3, 32'hE000, 5'd3,
             1, 2'd2, 0, 0, 0);
        probe("R9 slot 2 region released", 1, 32'h6000);
        step("R9 free slot 0", 0, 0, 0, 0, 0, 0, 1, 2'd0, 0, 0, 0);
        step("R9 free slot 1", 0, 0, 0, 0, 0, 0, 1, 2'd1, 0, 0, 0);
        step("R9 free slot 3", 0, 0, 0, 0, 0, 0, 1, 2'd3, 1, 1, 32'h8000);
        probe("R1 all free no stall", 1, 32'h8000);
        idle("R1 idle again");
        repeat (2) @(negedge clk);
        #5;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule